// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the status byte of a serial NOR flash and decides, for every decoded instruction, whether it takes effect. An SPI front end hands it one instruction at a time as a single-cycle strobe carrying the opcode, a 24-bit address and a data byte. The block also watches an active-low write-protect pin. It drives the current status byte continuously, so the front end can shift it out on every read-status byte slot. It reports a one-cycle accept or reject verdict for each instruction and raises busy while a timed status-write, program or erase cycle runs.

A write-type instruction must pass three gates. The write enable latch must be set. The block-protect field must not cover the target: the whole device for bulk erase, or the addressed 64 KB sector for page program and sector erase. For a status write, hardware protected mode must be off. An accepted write-type instruction starts a countdown whose length is a parameter for each kind of cycle. The non-volatile bits are plain registers loaded from a parameter at reset.

Top module: `flash_status_ctl`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: status-write-protect, constant 0, top/bottom select, BP2, BP1, BP0, write enable latch, write in progress. After reset the latch and busy bits are 0, bits 7 and 5..2 come from the INIT_NV parameter, and bit 6 is always 0.
- R2: Each strobed instruction produces exactly one of cmdAccept or cmdReject, in the cycle after the strobe. Neither is raised otherwise. Read status (05h) is always accepted, even while busy. An unknown opcode is rejected.
- R3: Write enable (06h) sets bit 1 and write disable (04h) clears it. Both are accepted when not busy.
- R4: While bit 1 is 0, write status (01h), page program (02h), sector erase (D8h) and bulk erase (C7h) are rejected and change nothing.
- R5: An accepted write-type instruction holds bit 0 and busy at 1 for exactly T_WRSR, T_PP, T_SE or T_BE clock cycles, counted from the edge that accepts it.
- R6: While bit 0 is 1, every instruction other than read status is rejected and has no effect.
- R7: Bit 1 clears at the edge where an accepted cycle ends. It also clears at once when a write-type instruction is rejected by protection while the latch is set.
- R8: Write status loads bits 7 and 5..2 from cmdData when its cycle ends. It is rejected when bit 7 is 1 and wpN is 0.
- R9: With protect value n = bits 4..2 and sector = cmdAddr[22:16] (bit 23 ignored), a page program or sector erase is rejected inside the protected area. For n = 0 nothing is protected. For n = 7 everything is protected. For n = 1..6 the protected area is the top 2^(n-1) sectors of 128 when bit 5 is 0, or the bottom 2^(n-1) sectors when bit 5 is 1.
- R10: Bulk erase is accepted only when bits 4..2 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle strobe of a decoded instruction |
| cmdOp | input | 8 | Opcode |
| cmdAddr | input | 24 | Byte address for program and sector erase |
| cmdData | input | 8 | Data byte for write status |
| wpN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Current status byte |
| cmdAccept | output | 1 | Instruction took effect |
| cmdReject | output | 1 | Instruction was ignored |
| busy | output | 1 | A timed cycle is running |

## Verification
The status byte is visible on every clock, so a wrong latch, busy or protect bit shows at the port in the cycle after the edge that caused it. The bench's behavioural model is compared against the status byte, busy and the verdict pair on every cycle. A wrong range decode or a wrong countdown length therefore shows as a verdict mismatch one cycle after the strobe, or as a busy mismatch on the first cycle the lengths disagree. A wrong status-write load stays hidden until its cycle ends, and then shows at once.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  // bits that live in non-volatile storage: b7, b5, b4, b3, b2
  localparam logic [7:0] NV_MASK = 8'hBC;

  typedef enum logic [1:0] {CYC_WRSR, CYC_PP, CYC_SE, CYC_BE} cyc_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic start;
    cyc_e kind;
  } strobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SECTOR_W   = 7,
  parameter int SECTOR_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wpN,
  input  logic [7:0]        status,
  output strobe_t           stb,
  output logic              cmdAccept,
  output logic              cmdReject
);
  localparam int SPAN_W = SECTOR_W + 1;
  localparam logic [SPAN_W-1:0] SECTORS = SPAN_W'(1) << SECTOR_W;

  logic [SECTOR_W-1:0] sector;
  logic [2:0]          bp;
  logic                tb, wel, wip, hwLock;
  logic [SPAN_W-1:0]   span;
  logic                inArea;
  logic                acc, rej;
  logic                unusedBits;

  assign sector = cmdAddr[SECTOR_LSB +: SECTOR_W];
  assign bp     = status[4:2];
  assign tb     = status[5];
  assign wel    = status[1];
  assign wip    = status[0];
  assign hwLock = status[7] && !wpN;
  assign unusedBits = ^{cmdAddr, status[6]};

  always_comb begin
    if (bp == 3'd0)      span = '0;
    else if (bp == 3'd7) span = SECTORS;
    else                 span = SPAN_W'(1) << (bp - 3'd1);
  end

  assign inArea = tb ? ({1'b0, sector} < span)
                     : ({1'b0, sector} >= (SECTORS - span));

  always_comb begin
    acc = 1'b0;
    rej = 1'b0;
    stb = '{setWel: 1'b0, clrWel: 1'b0, start: 1'b0, kind: CYC_WRSR};
    if (cmdValid) begin
      if (cmdOp == OP_RDSR) begin
        acc = 1'b1;
      end else if (wip) begin
        rej = 1'b1;
      end else begin
        unique case (cmdOp)
          OP_WREN: begin acc = 1'b1; stb.setWel = 1'b1; end
          OP_WRDI: begin acc = 1'b1; stb.clrWel = 1'b1; end
          OP_WRSR, OP_PP, OP_SE, OP_BE: begin
            stb.kind = (cmdOp == OP_WRSR) ? CYC_WRSR :
                       (cmdOp == OP_PP)   ? CYC_PP   :
                       (cmdOp == OP_SE)   ? CYC_SE   : CYC_BE;
            if (!wel) begin
              rej = 1'b1;
            end else if ((cmdOp == OP_WRSR && hwLock) ||
                         ((cmdOp == OP_PP || cmdOp == OP_SE) && inArea) ||
                         (cmdOp == OP_BE && bp != 3'd0)) begin
              rej = 1'b1;
              stb.clrWel = 1'b1;
            end else begin
              acc = 1'b1;
              stb.start = 1'b1;
            end
          end
          default: rej = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      cmdAccept <= acc;
      cmdReject <= rej;
    end
  end

  // R2: one verdict per strobe, none without a strobe
  assert_one_verdict_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (cmdAccept ^ cmdReject));
  assert_no_spurious_verdict_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !(cmdAccept || cmdReject));
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && wip && cmdOp != OP_RDSR) |=> cmdReject);
  assert_latch_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !wel && (cmdOp == OP_WRSR || cmdOp == OP_PP ||
                          cmdOp == OP_SE || cmdOp == OP_BE)) |=> cmdReject);
  assert_bulk_guard_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_BE && bp != 3'd0) |=> cmdReject);
endmodule

// File: rtl/fsc_dpath.sv
module fsc_dpath
  import fsc_pkg::*;
#(
  parameter int         CNT_W   = 16,
  parameter int         T_WRSR  = 6,
  parameter int         T_PP    = 3,
  parameter int         T_SE    = 5,
  parameter int         T_BE    = 9,
  parameter logic [7:0] INIT_NV = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:0] wrData,
  output logic [7:0] status
);
  localparam logic [CNT_W-1:0] LEN_WRSR = CNT_W'(T_WRSR - 1);
  localparam logic [CNT_W-1:0] LEN_PP   = CNT_W'(T_PP - 1);
  localparam logic [CNT_W-1:0] LEN_SE   = CNT_W'(T_SE - 1);
  localparam logic [CNT_W-1:0] LEN_BE   = CNT_W'(T_BE - 1);

  logic [7:0]       nvQ, pendQ;
  logic             welQ, wipQ, pendWrsr;
  logic [CNT_W-1:0] cntQ, lenSel;

  always_comb begin
    unique case (stb.kind)
      CYC_WRSR: lenSel = LEN_WRSR;
      CYC_PP:   lenSel = LEN_PP;
      CYC_SE:   lenSel = LEN_SE;
      default:  lenSel = LEN_BE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvQ      <= INIT_NV & NV_MASK;
      pendQ    <= '0;
      pendWrsr <= 1'b0;
      welQ     <= 1'b0;
      wipQ     <= 1'b0;
      cntQ     <= '0;
    end else if (wipQ) begin
      if (cntQ == '0) begin
        wipQ     <= 1'b0;
        welQ     <= 1'b0;
        pendWrsr <= 1'b0;
        if (pendWrsr) nvQ <= pendQ & NV_MASK;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end else if (stb.start) begin
      wipQ     <= 1'b1;
      cntQ     <= lenSel;
      pendWrsr <= (stb.kind == CYC_WRSR);
      pendQ    <= wrData;
    end else begin
      if (stb.setWel) welQ <= 1'b1;
      if (stb.clrWel) welQ <= 1'b0;
    end
  end

  assign status = nvQ | {6'b0, welQ, wipQ};

  // R5: a cycle only begins with the latch set, and runs on while time remains
  assert_start_needs_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wipQ) |-> welQ);
  assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wipQ && cntQ != '0) |=> wipQ);
  // R7: the latch is gone when a cycle ends
  assert_latch_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wipQ) |-> !welQ);
  // R8: protect bits never move while a cycle runs
  assert_nv_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    wipQ |-> $stable(nvQ));
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import fsc_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         SECTOR_W   = 7,
  parameter int         SECTOR_LSB = 16,
  parameter int         CNT_W      = 16,
  parameter int         T_WRSR     = 6,
  parameter int         T_PP       = 3,
  parameter int         T_SE       = 5,
  parameter int         T_BE       = 9,
  parameter logic [7:0] INIT_NV    = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wpN,
  output logic [7:0]        statusByte,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              busy
);
  strobe_t stb;

  fsc_ctrl #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .SECTOR_LSB(SECTOR_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .wpN(wpN), .status(statusByte), .stb(stb),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject));

  fsc_dpath #(.CNT_W(CNT_W), .T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE),
              .T_BE(T_BE), .INIT_NV(INIT_NV)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cmdData), .status(statusByte));

  assign busy = statusByte[0];

  // R1: bit 6 reads 0 and busy mirrors bit 0, seen at the ports
  assert_fixed_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[6] && (busy == statusByte[0]));
endmodule

// File: tb/flash_status_ctl_tb.sv
module flash_status_ctl_tb;
  localparam int T_WRSR = 6, T_PP = 3, T_SE = 5, T_BE = 9;

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0, wpN = 1'b1;
  logic [7:0] cmdOp = '0, cmdData = '0;
  logic [23:0] cmdAddr = '0;
  logic [7:0] statusByte;
  logic cmdAccept, cmdReject, busy;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_status_ctl #(.T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE),
                     .INIT_NV(8'h00)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .wpN(wpN), .statusByte(statusByte),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .busy(busy));

  // behavioural reference: remaining-time counter, verdicts from rules
  int mNv = 0, mWel = 0, mWip = 0, mLeft = 0, mPend = 0, mPendW = 0;
  bit mAcc = 0, mRej = 0;

  function automatic bit inProtected(int nv, int addr);
    int n, size, sec;
    n = (nv >> 2) & 7;
    sec = (addr >> 16) & 127;
    if (n == 0) return 0;
    if (n == 7) return 1;
    size = 1 << (n - 1);
    if ((nv >> 5) & 1) return sec < size;
    return sec >= 128 - size;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mNv = 0; mWel = 0; mWip = 0; mLeft = 0; mPendW = 0; mAcc = 0; mRej = 0;
    end else begin
      bit a, r, isWrite, blocked;
      int len, preWip, preWel;
      a = 0; r = 0; len = 0;
      preWip = mWip; preWel = mWel;
      if (mWip != 0) begin
        mLeft--;
        if (mLeft == 0) begin
          mWip = 0; mWel = 0;
          if (mPendW != 0) mNv = mPend & 8'hBC;
          mPendW = 0;
        end
      end
      if (cmdValid) begin
        isWrite = (cmdOp == 8'h01 || cmdOp == 8'h02 || cmdOp == 8'hD8 || cmdOp == 8'hC7);
        if (cmdOp == 8'h05) a = 1;
        else if (preWip != 0) r = 1;
        else if (cmdOp == 8'h06) begin a = 1; mWel = 1; end
        else if (cmdOp == 8'h04) begin a = 1; mWel = 0; end
        else if (isWrite) begin
          blocked = 0;
          if (cmdOp == 8'h01) begin blocked = ((mNv >> 7) & 1) && !wpN; len = T_WRSR; end
          if (cmdOp == 8'h02) begin blocked = inProtected(mNv, int'(cmdAddr)); len = T_PP; end
          if (cmdOp == 8'hD8) begin blocked = inProtected(mNv, int'(cmdAddr)); len = T_SE; end
          if (cmdOp == 8'hC7) begin blocked = ((mNv >> 2) & 7) != 0; len = T_BE; end
          if (preWel == 0) r = 1;
          else if (blocked) begin r = 1; mWel = 0; end
          else begin
            a = 1; mWip = 1; mLeft = len;
            mPendW = (cmdOp == 8'h01); mPend = int'(cmdData);
          end
        end else r = 1;
      end
      mAcc = a; mRej = r;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(statusByte == 8'(mNv | (mWel << 1) | mWip), "R1 status vs model",
            int'(statusByte), mNv | (mWel << 1) | mWip);
      check(busy == mWip[0], "R5 busy vs model", int'(busy), mWip);
      check({cmdAccept, cmdReject} == {mAcc, mRej}, "R2 verdict vs model",
            int'({cmdAccept, cmdReject}), int'({mAcc, mRej}));
    end
  end

  task automatic issue(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d,
                       input bit expAcc, input string tag);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    check(cmdAccept == expAcc && cmdReject == !expAcc, tag, int'(cmdAccept), int'(expAcc));
  endtask

  task automatic expectStatus(input logic [7:0] exp, input string tag);
    check(statusByte == exp, tag, int'(statusByte), int'(exp));
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectStatus(8'h00, "R1 reset state");
    issue(8'h02, 24'h000000, 8'h00, 1'b0, "R4 program without latch");
    expectStatus(8'h00, "R4 nothing changed");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 write enable");
    expectStatus(8'h02, "R3 latch set");
    issue(8'h04, 24'h0, 8'h00, 1'b1, "R3 write disable");
    expectStatus(8'h00, "R3 latch cleared");
    issue(8'h01, 24'h0, 8'hFF, 1'b0, "R4 status write without latch");
    // status write of FF
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h01, 24'h0, 8'hFF, 1'b1, "R8 status write accepted");
    expectStatus(8'h03, "R5 busy with latch held");
    issue(8'h05, 24'h0, 8'h00, 1'b1, "R2 read status while busy");
    issue(8'h06, 24'h0, 8'h00, 1'b0, "R6 enable ignored while busy");
    waitIdle();
    expectStatus(8'hBC, "R8 R7 loaded bits, latch cleared");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'hC7, 24'h0, 8'h00, 1'b0, "R10 bulk erase blocked");
    expectStatus(8'hBC, "R7 latch cleared on protection reject");
    wpN = 1'b0;
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h01, 24'h0, 8'h00, 1'b0, "R8 hardware protected reject");
    expectStatus(8'hBC, "R8 bits kept");
    wpN = 1'b1;
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h01, 24'h0, 8'h28, 1'b1, "R8 write bottom n=2");
    waitIdle();
    expectStatus(8'h28, "R8 bottom n=2 loaded");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h02, 24'h01_0000, 8'h00, 1'b0, "R9 bottom sector 1 protected");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h02, 24'h02_0000, 8'h00, 1'b1, "R9 bottom sector 2 open");
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == T_PP, "R5 program length", n, T_PP);
    @(negedge clk);
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'hD8, 24'h81_0000, 8'h00, 1'b0, "R9 bit 23 ignored, sector 1");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h01, 24'h0, 8'h0C, 1'b1, "R8 write top n=3");
    waitIdle();
    expectStatus(8'h0C, "R8 top n=3 loaded");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'hD8, 24'h7C_0000, 8'h00, 1'b0, "R9 top sector 124 protected");
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'hD8, 24'h7B_0000, 8'h00, 1'b1, "R9 top sector 123 open");
    waitIdle();
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'h01, 24'h0, 8'h00, 1'b1, "R8 clear protect");
    waitIdle();
    issue(8'h06, 24'h0, 8'h00, 1'b1, "R3 enable");
    issue(8'hC7, 24'h0, 8'h00, 1'b1, "R10 bulk erase with n=0");
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == T_BE, "R5 bulk erase length", n, T_BE);
    expectStatus(8'h00, "R7 latch cleared after erase");
    issue(8'hAB, 24'h0, 8'h00, 1'b0, "R2 unknown opcode");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule